// File: doc/BRIEF.md
# Time-Slot Gated PRBS Inserter

This block produces a 2^15-1 pseudorandom test pattern and places it into a serial bit stream. The stream is organised as frames of 256 bit times, which form 32 time slots of eight bits each. On every bit time the block either forwards the normal transmit bit or puts the next pattern bit in its place. A two-bit mode input chooses where the pattern goes: nowhere, into one selected slot, into every slot except slot 0, or into every bit of the frame.

A frame-start pulse marks bit 0 of slot 0. An internal position counter restarts on that pulse and otherwise runs freely, wrapping at the frame length. The pattern register moves forward only on the bit times that carry pattern bits. As a result, the sequence continues without a break across the gaps made by normal data. The output is registered, so each bit leaves the block one clock after its input was presented.

Top module: `prbs_slot_inserter`

## Requirements
- R1: While rst_ni is low, data_o is 0, the frame position is 0 and every stage of the pattern register is 1. Because of this seed, the first 15 pattern bits sent after reset are all 0.
- R2: A frame_start_i high on a bit time makes that bit time position 0. Without frame_start_i the position goes up by one per clock and wraps from 255 to 0. The slot number is the position divided by 8.
- R3: With mode_i = 2'b00, data_o equals the data_i that was presented one clock earlier.
- R4: With mode_i = 2'b01, pattern bits replace data_i only while the current slot equals slot_sel_i. All other slots pass data_i.
- R5: With mode_i = 2'b10, pattern bits replace data_i in slots 1 to 31. Slot 0 passes data_i.
- R6: With mode_i = 2'b11, every bit time carries a pattern bit, whatever the frame position.
- R7: The pattern register is 15 stages long, numbered 1 to 15. On each advance, stage 14 XOR stage 15 enters stage 1. The bit sent is the inverse of stage 15 before the advance.
- R8: The pattern register advances only on bit times that carry a pattern bit. After any number of pass-through bit times, the pattern resumes with the bit that follows the last one sent.
- R9: mode_i, slot_sel_i, frame_start_i and data_i are sampled on each rising clock edge. The resulting bit appears on data_o after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | High on the bit time that is bit 0 of slot 0 |
| mode_i | input | 2 | Pattern placement: 00 off, 01 one slot, 10 slots 1-31, 11 all bits |
| slot_sel_i | input | 5 | Slot that carries the pattern when the mode is 01 |
| data_i | input | 1 | Normal transmit bit |
| data_o | output | 1 | Serial output after the pattern mux |

## Verification
Every result is due one clock after its stimulus: the inputs presented for a bit time decide the data_o value seen after the next rising edge. The driver works out each expected bit when it drives the inputs, from its own position counter and its own model of the pattern register, and queues that bit. The monitor takes exactly one entry from the queue per clock, sampling one nanosecond after the edge, so every comparison lines up with the bit time that produced it. Runs in every mode, frame resynchronisation in mid-frame, and wrap-around without a marker all pass through the same path.

// File: rtl/prbs_slot_pkg.sv
package prbs_slot_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_SLOT   = 2'b01,
    MODE_FRAMED = 2'b10,
    MODE_ALL    = 2'b11
  } place_mode_e;
endpackage

// File: rtl/frame_pos_counter.sv
module frame_pos_counter #(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned FRAME_LEN = SLOT_BITS * NUM_SLOTS,
  localparam int unsigned POS_W     = $clog2(FRAME_LEN),
  localparam int unsigned BIT_W     = $clog2(SLOT_BITS),
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_cur;

  // the marker overrides the stored position on its own bit time
  assign pos_cur = frame_start_i ? '0 : pos_q;
  assign slot_o  = SLOT_W'(pos_cur / POS_W'(SLOT_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else if (pos_cur == LAST_POS) pos_q <= '0;
    else pos_q <= pos_cur + POS_W'(1);
  end

  p_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> pos_q == POS_W'(1));
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_start_i && pos_q == LAST_POS) |=> pos_q == '0);
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_start_i && pos_q != LAST_POS) |=> pos_q == $past(pos_q) + POS_W'(1));
endmodule

// File: rtl/slot_gate.sv
module slot_gate
  import prbs_slot_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] slot_sel_i,
  output logic              insert_o
);
  place_mode_e mode;
  assign mode = place_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_OFF:    insert_o = 1'b0;
      MODE_SLOT:   insert_o = (slot_i == slot_sel_i);
      MODE_FRAMED: insert_o = (slot_i != '0);
      MODE_ALL:    insert_o = 1'b1;
      default:     insert_o = 1'b0;
    endcase
  end

  p_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |-> !insert_o);
  p_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |-> insert_o);
  p_slot0_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && slot_i == '0) |-> !insert_o);
  p_other_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && slot_i != slot_sel_i) |-> !insert_o);
endmodule

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
  parameter int unsigned LEN        = 15,
  parameter int unsigned TAP        = 14,
  parameter bit          INVERT_OUT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic bit_o
);
  logic [LEN-1:0] state_q;
  logic           fb;

  assign fb = state_q[LEN-1] ^ state_q[TAP-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '1;
    else if (adv_i) state_q <= {state_q[LEN-2:0], fb};
  end

  generate
    if (INVERT_OUT) begin : g_inv
      assign bit_o = ~state_q[LEN-1];
    end else begin : g_true
      assign bit_o = state_q[LEN-1];
    end
  endgenerate

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q));
  p_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  p_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> state_q[LEN-1:1] == $past(state_q[LEN-2:0]));
endmodule

// File: rtl/prbs_slot_inserter.sv
module prbs_slot_inserter #(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned PRBS_LEN  = 15,
  parameter int unsigned PRBS_TAP  = 14,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [1:0]        mode_i,
  input  logic [SLOT_W-1:0] slot_sel_i,
  input  logic              data_i,
  output logic              data_o
);
  logic [SLOT_W-1:0] slot;
  logic              insert;
  logic              prbs_bit;

  frame_pos_counter #(.SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)) u_pos (
    .clk_i, .rst_ni, .frame_start_i, .slot_o(slot)
  );

  slot_gate #(.NUM_SLOTS(NUM_SLOTS)) u_gate (
    .clk_i, .rst_ni, .mode_i, .slot_i(slot), .slot_sel_i, .insert_o(insert)
  );

  prbs_lfsr #(.LEN(PRBS_LEN), .TAP(PRBS_TAP), .INVERT_OUT(1'b1)) u_lfsr (
    .clk_i, .rst_ni, .adv_i(insert), .bit_o(prbs_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= 1'b0;
    else data_o <= insert ? prbs_bit : data_i;
  end

  p_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> data_o == $past(data_i));
  p_framed_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && frame_start_i) |=> data_o == $past(data_i));
  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> !data_o);
endmodule

// File: tb/prbs_slot_inserter_tb.sv
`timescale 1ns/1ps
module prbs_slot_inserter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [4:0] sel = 5'd0;
  logic       din = 1'b0;
  logic       dout;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit reported = 1'b0;

  logic [7:0]  m_pos   = 8'd0;
  logic [14:0] m_state = 15'h7fff;
  logic        exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  prbs_slot_inserter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .mode_i(mode),
    .slot_sel_i(sel), .data_i(din), .data_o(dout)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: data_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: present one bit time and queue its expected output
  task automatic send(input logic f, input logic [1:0] m, input logic [4:0] s, input logic d);
    logic [7:0] pos;
    logic [4:0] slot;
    logic       ins, e;
    string      tag;
    @(negedge clk);
    fs = f; mode = m; sel = s; din = d;
    pos  = f ? 8'd0 : m_pos;
    slot = pos[7:3];
    case (m)
      2'b00: begin ins = 1'b0; tag = "R3"; end
      2'b01: begin ins = (slot == s); tag = "R4"; end
      2'b10: begin ins = (slot != 5'd0); tag = "R5"; end
      default: begin ins = 1'b1; tag = "R6"; end
    endcase
    if (ins) begin
      e = ~m_state[14];
      m_state = {m_state[13:0], m_state[14] ^ m_state[13]};
      tag = {tag, "/R7/R8"};
    end else e = d;
    if (f) tag = {tag, "/R2"};
    m_pos = pos + 8'd1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic frames(input int nbits, input logic [1:0] m, input logic [4:0] s, input bit mark);
    for (int i = 0; i < nbits; i++)
      send(mark && (i % 256 == 0), m, s, logic'($urandom_range(0, 1)));
  endtask

  // monitor: one queued result per clock, taken just after the edge (R9)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(dout, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic report;
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dout, 1'b0, "R1 reset output");
    rst_n = 1'b1;
    // first 15 pattern bits after reset are 0 (R1)
    for (int i = 0; i < 15; i++) send(i == 0, 2'b11, 5'd0, 1'b1);
    frames(512 - 15, 2'b11, 5'd0, 1'b0);
    frames(300, 2'b00, 5'd0, 1'b1);
    frames(512, 2'b01, 5'd5, 1'b1);
    frames(512, 2'b01, 5'd31, 1'b1);
    frames(512, 2'b01, 5'd0, 1'b1);
    frames(512, 2'b10, 5'd0, 1'b1);
    // resync in mid-frame (R2)
    frames(100, 2'b10, 5'd0, 1'b0);
    frames(600, 2'b10, 5'd0, 1'b1);
    // no marker: counter wraps on its own (R2)
    frames(700, 2'b01, 5'd2, 1'b0);
    frames(300, 2'b11, 5'd0, 1'b0);
    // explicit latency check (R9): one bit in mode 00
    send(1'b0, 2'b00, 5'd0, 1'b1);
    send(1'b0, 2'b00, 5'd0, 1'b0);
    send(1'b0, 2'b00, 5'd0, 1'b1);
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    check(dout, 1'b1, "R9 last bit held after one clock");
    done = 1'b1;
    report();
  end
endmodule